// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a byte-register SPI master that runs a single flash command per start request. Software places an opcode in a dedicated register, programs a write count and a read count, loads outgoing bytes through a byte-wide data window into an 8-entry ring, and sets the start bit. The engine pulls chip select low, sends the opcode, sends the write bytes taken from the ring, and then clocks the read bytes while driving MOSI high. Chip select then rises again.

Every byte clocked after the opcode is stored back into the same ring at the pointer. This holds for the write phase as well as the read phase, so the write phase leaves the slave's echo bytes in the ring. The ring is never cleared. To collect a response, software rewinds the single pointer, reads past as many entries as it wrote, and then reads the response bytes. The pointer is visible in the status register so software can confirm where the engine stopped.

The sequencer has six named states:
- ST_IDLE: waiting, chip select high. It moves to ST_SETUP on a start request.
- ST_SETUP: chip select low. It launches the opcode byte and moves to ST_OPCODE.
- ST_OPCODE: waits for the opcode byte to finish, then moves to ST_NEXT.
- ST_NEXT: launches a write byte, or else a read byte, and moves to ST_XFER. When no bytes remain it moves to ST_DONE.
- ST_XFER: waits for the byte to finish, stores the received byte, and returns to ST_NEXT.
- ST_DONE: chip select high and busy still set. It returns to ST_IDLE.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, the status register reads 0, and the opcode and count registers read 0.
- R2: The opcode register (offset 0x0) and the count register (offset 0x1) read back exactly the last value written. The count register's bits 7:4 are the read count and bits 3:0 are the write count, and any nibble value reads back unchanged.
- R3: Each write or read of the data window (offset 0xC) accesses the ring entry at the pointer and then advances the pointer by one, modulo 8.
- R4: Writing 1 to bit 1 of the control register (offset 0x2) sets the pointer to 0 and leaves the stored bytes unchanged.
- R5: Writing 1 to bit 0 of the control register starts a command. spi_cs_n stays low for the whole command and the opcode byte is sent first. Data is MSB first in mode 0: SCLK idles low, and MOSI never changes while SCLK is high.
- R6: The write bytes are taken from the ring in order, starting at the pointer value held when the command starts.
- R7: For every byte after the opcode, the byte sampled on MISO is written into the ring at the pointer, and the pointer then advances.
- R8: The engine clocks exactly 8×(1+W+R) SCLK rising edges and drives MOSI as 0xFF during read bytes. W and R are the count nibbles, each clamped to 8. With W equal to 0 it still clocks all R read bytes.
- R9: After a command, the pointer equals its start value plus W plus R, modulo 8. Status bits 6:4 show the pointer.
- R10: Status bit 0 (busy) reads 1 from the cycle after the start request until chip select has gone high.
- R11: While busy is set, writes to the opcode, count, data and control registers are ignored, and reads of the data window do not advance the pointer.
- R12: One SCLK period lasts CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the pointer on the data window) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The bench runs random opcodes with random write and read counts from 0 to 8, and starts each command from a random pointer so that the write and echo regions wrap around the ring. The bench slave supplies random bytes, which separates bytes sent from the ring from bytes stored in the ring.

Several directed cases are added:
- Opcode only, and write count 0 with reads. These show whether any response byte is dropped.
- Both counts at 8, and count nibbles of 0xF. These cover the full overwrite of the ring and the clamping.
- Register writes and a data-window read issued while busy. These show whether any of them leak into the opcode, the counts, the ring or the pointer.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_OPCODE,
        ST_NEXT,
        ST_XFER,
        ST_DONE
    } seq_state_e;

    localparam logic [3:0] OFS_OPCODE = 4'h0;
    localparam logic [3:0] OFS_COUNT  = 4'h1;
    localparam logic [3:0] OFS_CTRL   = 4'h2;
    localparam logic [3:0] OFS_STAT   = 4'h3;
    localparam logic [3:0] OFS_DATA   = 4'hC;

    localparam int CTRL_GO_BIT     = 0;
    localparam int CTRL_REWIND_BIT = 1;
    localparam int STAT_BUSY_BIT   = 0;
    localparam int STAT_PTR_LSB    = 4;

    localparam logic [7:0] READ_FILL = 8'hFF;

endpackage

// File: rtl/spi_ring.sv
module spi_ring #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          adv,
    input  logic          rewind,
    output logic [7:0]    rd_data,
    output logic [PW-1:0] ptr
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rewind) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        end
    end

    assign rd_data = mem[ptr];

endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    localparam int HALF = CLK_DIV / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HW-1:0] half_cnt;
    logic [2:0]    bit_cnt;
    logic          active;
    logic          sclk_q;
    logic [7:0]    tx_sr;
    logic [7:0]    rx_sr;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt <= '0;
            bit_cnt  <= '0;
            active   <= 1'b0;
            sclk_q   <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active   <= 1'b1;
                tx_sr    <= tx_byte;
                half_cnt <= '0;
                bit_cnt  <= '0;
                sclk_q   <= 1'b0;
            end else if (active) begin
                if (half_cnt == HW'(HALF - 1)) begin
                    half_cnt <= '0;
                    sclk_q   <= ~sclk_q;
                    if (!sclk_q) begin
                        rx_sr <= {rx_sr[6:0], miso};
                    end else if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sr   <= {tx_sr[6:0], 1'b0};
                    end
                end else begin
                    half_cnt <= half_cnt + 1'b1;
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = tx_sr[7];
    assign done    = done_q;
    assign rx_byte = rx_sr;

endmodule

// File: rtl/spi_seq.sv
module spi_seq
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [3:0] wr_cfg,
    input  logic [3:0] rd_cfg,
    input  logic [7:0] opcode,
    input  logic [7:0] ring_q,
    input  logic       sh_done,
    output logic       sh_start,
    output logic [7:0] sh_tx,
    output logic       store,
    output logic       cs_n,
    output logic       busy
);

    localparam int CW = $clog2(DEPTH + 1);

    function automatic logic [CW-1:0] clamp(input logic [3:0] n);
        return (32'(n) > DEPTH) ? CW'(DEPTH) : CW'(n);
    endfunction

    seq_state_e    state, nxt;
    logic [CW-1:0] wleft, rleft;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            wleft <= '0;
            rleft <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && go) begin
                wleft <= clamp(wr_cfg);
                rleft <= clamp(rd_cfg);
            end else if (state == ST_NEXT) begin
                if (wleft != '0)      wleft <= wleft - 1'b1;
                else if (rleft != '0) rleft <= rleft - 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_SETUP;
            ST_SETUP:  nxt = ST_OPCODE;
            ST_OPCODE: if (sh_done) nxt = ST_NEXT;
            ST_NEXT:   nxt = (wleft != '0 || rleft != '0) ? ST_XFER : ST_DONE;
            ST_XFER:   if (sh_done) nxt = ST_NEXT;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = opcode;
        store    = 1'b0;
        cs_n     = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                cs_n = 1'b1;
                busy = 1'b0;
            end
            ST_SETUP: sh_start = 1'b1;
            ST_OPCODE: ;
            ST_NEXT: begin
                sh_start = (wleft != '0) || (rleft != '0);
                sh_tx    = (wleft != '0) ? ring_q : READ_FILL;
            end
            ST_XFER: store = sh_done;
            ST_DONE: cs_n = 1'b1;
            default: cs_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);

    localparam int PW = $clog2(DEPTH);

    logic [7:0]    opcode_q;
    logic [7:0]    counts_q;
    logic          busy;
    logic          wr_ok;
    logic          go, rewind;
    logic          store;
    logic          ring_we, ring_adv;
    logic [7:0]    ring_wd, ring_q;
    logic [PW-1:0] ptr;
    logic          sh_start, sh_done;
    logic [7:0]    sh_tx, sh_rx;

    assign wr_ok  = reg_wr && !busy;
    assign go     = wr_ok && reg_addr == OFS_CTRL && reg_wdata[CTRL_GO_BIT];
    assign rewind = wr_ok && reg_addr == OFS_CTRL && reg_wdata[CTRL_REWIND_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            opcode_q <= '0;
            counts_q <= '0;
        end else begin
            if (wr_ok && reg_addr == OFS_OPCODE) opcode_q <= reg_wdata;
            if (wr_ok && reg_addr == OFS_COUNT)  counts_q <= reg_wdata;
        end
    end

    assign ring_we  = store || (wr_ok && reg_addr == OFS_DATA);
    assign ring_wd  = store ? sh_rx : reg_wdata;
    assign ring_adv = ring_we || (reg_rd && !busy && reg_addr == OFS_DATA);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_OPCODE: reg_rdata = opcode_q;
            OFS_COUNT:  reg_rdata = counts_q;
            OFS_STAT: begin
                reg_rdata[STAT_BUSY_BIT]         = busy;
                reg_rdata[STAT_PTR_LSB +: PW]    = ptr;
            end
            OFS_DATA:   reg_rdata = ring_q;
            default:    reg_rdata = '0;
        endcase
    end

    spi_ring #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ring_we),
        .wr_data (ring_wd),
        .adv     (ring_adv),
        .rewind  (rewind),
        .rd_data (ring_q),
        .ptr     (ptr)
    );

    spi_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    spi_seq #(.DEPTH(DEPTH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .wr_cfg   (counts_q[3:0]),
        .rd_cfg   (counts_q[7:4]),
        .opcode   (opcode_q),
        .ring_q   (ring_q),
        .sh_done  (sh_done),
        .sh_start (sh_start),
        .sh_tx    (sh_tx),
        .store    (store),
        .cs_n     (spi_cs_n),
        .busy     (busy)
    );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    reg_addr,
    input logic          reg_wr,
    input logic [7:0]    reg_wdata,
    input logic          spi_sclk,
    input logic          spi_mosi,
    input logic          spi_cs_n,
    input logic          busy,
    input logic [PW-1:0] ptr,
    input logic [7:0]    opcode_q,
    input logic [7:0]    counts_q
);

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    p_mosi_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    p_cs_busy_r10: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy);

    p_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'h2 && reg_wdata[0] && !busy) |=> busy);

    p_rewind_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'h2 && reg_wdata[1] && !busy) |=> ptr == '0);

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
        ptr == $past(ptr) || ptr == PW'($past(ptr) + 1'b1) || ptr == '0);

    p_opcode_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(opcode_q));

    p_counts_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(counts_q));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n),
    .busy      (busy),
    .ptr       (ptr),
    .opcode_q  (opcode_q),
    .counts_q  (counts_q)
);

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;

    localparam int CLK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] mref [8];
    logic [7:0] slv  [17];
    logic [7:0] cap  [17];
    int         edges = 0;
    realtime    t0 = 0.0, t1 = 0.0;

    always #5 clk = ~clk;

    spi_cmd_engine #(.DEPTH(8), .CLK_DIV(CLK_DIV)) dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    function automatic logic slv_bit(input int b);
        if (b / 8 > 16) return 1'b0;
        return slv[b / 8][7 - (b % 8)];
    endfunction

    always @(negedge spi_cs_n) begin
        edges = 0;
        for (int i = 0; i < 17; i++) cap[i] = '0;
        spi_miso = slv_bit(0);
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (edges == 0) t0 = $realtime;
            if (edges == 1) t1 = $realtime;
            if (edges / 8 < 17) cap[edges / 8] = {cap[edges / 8][6:0], spi_mosi};
            edges = edges + 1;
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) spi_miso = slv_bit(edges);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic int clamp8(input int n);
        return (n > 8) ? 8 : n;
    endfunction

    task automatic run_cmd(input logic [7:0] op, input logic [7:0] cnt, input bit inject);
        int w, r, p0, n;
        logic [7:0] d;
        w = clamp8(int'(cnt[3:0]));
        r = clamp8(int'(cnt[7:4]));
        wr(4'h0, op);
        wr(4'h1, cnt);
        wr(4'h2, 8'h02);
        for (int i = 0; i < 8; i++) begin
            d = 8'($urandom);
            wr(4'hC, d);
            mref[i] = d;
        end
        p0 = $urandom_range(0, 7);
        for (int i = 0; i < p0; i++) begin
            rd(4'hC, d);
            chk(d == mref[i], "R3 data window read", int'(d), int'(mref[i]));
        end
        rd(4'h3, d);
        chk(int'(d[6:4]) == p0, "R3 pointer advance", int'(d[6:4]), p0);
        for (int i = 0; i < 17; i++) slv[i] = 8'($urandom);
        wr(4'h2, 8'h01);
        rd(4'h3, d);
        chk(d[0] == 1'b1, "R10 busy after start", int'(d[0]), 1);
        if (inject) begin
            wr(4'h0, ~op);
            wr(4'h1, 8'h00);
            wr(4'hC, 8'hA5);
            rd(4'hC, d);
            wr(4'h2, 8'h02);
        end
        n = 0;
        do begin
            rd(4'h3, d);
            n++;
        end while (d[0] && n < 5000);
        chk(spi_cs_n == 1'b1, "R10 cs high when idle", int'(spi_cs_n), 1);
        chk(edges == 8 * (1 + w + r), "R8 sclk edge count", edges, 8 * (1 + w + r));
        chk(cap[0] == op, "R5 opcode first", int'(cap[0]), int'(op));
        for (int i = 0; i < w; i++)
            chk(cap[1 + i] == mref[(p0 + i) % 8], "R6 write byte", int'(cap[1 + i]), int'(mref[(p0 + i) % 8]));
        for (int i = 0; i < r; i++)
            chk(cap[1 + w + i] == 8'hFF, "R8 read fill", int'(cap[1 + w + i]), 255);
        chk((t1 - t0) == CLK_DIV * 10.0, "R12 sclk period", int'(t1 - t0), CLK_DIV * 10);
        for (int i = 0; i < w + r; i++) mref[(p0 + i) % 8] = slv[1 + i];
        chk(int'(d[6:4]) == (p0 + w + r) % 8, "R9 final pointer", int'(d[6:4]), (p0 + w + r) % 8);
        rd(4'h1, d);
        chk(d == cnt, "R2 count readback", int'(d), int'(cnt));
        rd(4'h0, d);
        chk(d == op, "R2 R11 opcode readback", int'(d), int'(op));
        wr(4'h2, 8'h02);
        for (int i = 0; i < 8; i++) begin
            rd(4'hC, d);
            chk(d == mref[i], "R7 ring holds received bytes", int'(d), int'(mref[i]));
        end
        wr(4'h2, 8'h02);
        rd(4'h3, d);
        chk(d == 8'h00, "R4 rewind to zero", int'(d), 0);
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk(spi_cs_n == 1'b1, "R1 cs idle", int'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0, "R1 sclk idle", int'(spi_sclk), 0);
        rd(4'h3, d); chk(d == 8'h00, "R1 status", int'(d), 0);
        rd(4'h1, d); chk(d == 8'h00, "R1 count", int'(d), 0);
        rd(4'h0, d); chk(d == 8'h00, "R1 opcode", int'(d), 0);
        // R4 directed: rewind keeps data
        wr(4'hC, 8'h11); wr(4'hC, 8'h22); wr(4'hC, 8'h33);
        wr(4'h2, 8'h02);
        rd(4'hC, d); chk(d == 8'h11, "R4 data kept", int'(d), 8'h11);
        rd(4'hC, d); chk(d == 8'h22, "R4 data kept", int'(d), 8'h22);
        // directed corners
        run_cmd(8'h9F, 8'h30, 1'b1);
        run_cmd(8'h06, 8'h00, 1'b0);
        run_cmd(8'h0B, 8'h88, 1'b0);
        run_cmd(8'h5A, 8'hFF, 1'b1);
        run_cmd(8'h02, 8'h08, 1'b0);
        run_cmd(8'h05, 8'h10, 1'b0);
        for (int k = 0; k < 25; k++)
            run_cmd(8'($urandom),
                    {4'($urandom_range(0, 8)), 4'($urandom_range(0, 8))},
                    1'($urandom_range(0, 1)));
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule